// File: doc/BRIEF.md
# Overlaid Single/Double Floating-Point Register Bank

This block is the storage for floating-point operands. It holds raw bit patterns and performs no arithmetic. The storage is a set of 32-bit words. Each 64-bit double register is laid over a pair of neighbouring words, so a value written through one view is visible at once through the other. Integers written to a single register keep their two's-complement bits exactly.

The block has four ways in and out:
- a 32-bit single port, addressed by a 4-bit field plus a 1-bit extension;
- a 64-bit double port, addressed by a 4-bit register number;
- a paired-transfer port, which moves two 32-bit core-register values into one double register at once, or returns its two halves as two separate 32-bit values;
- the core integer registers, which live outside the block and appear here only as data buses.

Reads are combinational. Writes land on the rising clock edge. A build-time parameter chooses which word of a pair holds the upper half of a double.

Top module: `fpa_regfile`

## Requirements
- R1: After reset every storage word reads as zero through the single, double and paired ports.
- R2: The single index is the 4-bit field in index bits 4..1 with the extension bit as index bit 0, so field f with extension e selects word 2f+e.
- R3: A single write stores its 32 data bits unchanged at the next rising edge, including negative integers.
- R4: Double register n consists of words 2n and 2n+1. With SWAP_WORDS=0, data bits 31..0 sit in word 2n and bits 63..32 in word 2n+1.
- R5: With SWAP_WORDS=1, data bits 63..32 sit in word 2n and bits 31..0 in word 2n+1.
- R6: A paired write puts the first value in word 2m and the second in word 2m+1, whatever SWAP_WORDS is. The paired read returns word 2m as first and word 2m+1 as second.
- R7: A double write followed by a double read of the same register returns the same 64 bits.
- R8: When writes overlap on a word in one cycle, the single write wins over both others, and the paired write wins over the double write. Words that are not contested still take their own writer's data.
- R9: In a cycle with no write enable, no word changes.
- R10: Every read port reflects a change of its index in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sgRdField | input | 4 | Single read index, upper field |
| sgRdExt | input | 1 | Single read index, extension bit |
| sgRdData | output | 32 | Single read data |
| sgWrEn | input | 1 | Single write enable |
| sgWrField | input | 4 | Single write index, upper field |
| sgWrExt | input | 1 | Single write index, extension bit |
| sgWrData | input | 32 | Single write data |
| dbRdIdx | input | 4 | Double read register number |
| dbRdData | output | 64 | Double read data |
| dbWrEn | input | 1 | Double write enable |
| dbWrIdx | input | 4 | Double write register number |
| dbWrData | input | 64 | Double write data |
| prIdx | input | 4 | Paired transfer register number (read and write) |
| prWrEn | input | 1 | Paired write enable |
| prWrFirst | input | 32 | First core value, goes to the even word |
| prWrSecond | input | 32 | Second core value, goes to the odd word |
| prRdFirst | output | 32 | Even word of the selected register |
| prRdSecond | output | 32 | Odd word of the selected register |

## Verification
The contested case is a 32-bit write and a 64-bit write (double or paired) that land on the same word in the same cycle. Directed cycles force all three writers onto one register. Further cycles put double and paired writes together, and double and single writes together. The random phase also often aligns the indices of all three writers.

After each of these cycles, every view of the register is compared with a reference model. The model applies the double write first, then the paired write, then the single write. Both word orders are instantiated side by side to check that the uncontested half of the double went to the right word.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int unsigned SGL_W     = 32;
  localparam int unsigned DBL_REGS  = 16;
  localparam int unsigned NUM_WORDS = 2 * DBL_REGS;
  localparam int unsigned DBL_W     = 2 * SGL_W;
  localparam int unsigned DIDX_W    = $clog2(DBL_REGS);
  localparam int unsigned SIDX_W    = DIDX_W + 1;

  typedef logic [SIDX_W-1:0] sIdx_t;
  typedef logic [DIDX_W-1:0] dIdx_t;

  // per-word write strobes, already priority-resolved (at most one set per word)
  typedef struct packed {
    logic [NUM_WORDS-1:0] takeSgl;
    logic [NUM_WORDS-1:0] takePair;
    logic [NUM_WORDS-1:0] takeDbl;
  } wrStrobes_t;

  function automatic sIdx_t composeSgl(input dIdx_t field, input logic ext);
    return {field, ext};
  endfunction
endpackage

// File: rtl/fpa_wr_ctrl.sv
module fpa_wr_ctrl
  import fpa_pkg::*;
(
  input  logic       sgWrEn,
  input  sIdx_t      sgWrIdx,
  input  logic       prWrEn,
  input  dIdx_t      prIdx,
  input  logic       dbWrEn,
  input  dIdx_t      dbWrIdx,
  output wrStrobes_t strobes
);
  logic [NUM_WORDS-1:0] takeS, takeP, takeD;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_arb
    localparam dIdx_t OWNER = dIdx_t'(w / 2);
    logic hitS, hitP, hitD;
    assign hitS = sgWrEn && (sgWrIdx == sIdx_t'(w));
    assign hitP = prWrEn && (prIdx == OWNER);
    assign hitD = dbWrEn && (dbWrIdx == OWNER);
    // priority: single, then paired, then double
    assign takeS[w] = hitS;
    assign takeP[w] = hitP && !hitS;
    assign takeD[w] = hitD && !hitS && !hitP;
  end

  assign strobes.takeSgl  = takeS;
  assign strobes.takePair = takeP;
  assign strobes.takeDbl  = takeD;
endmodule

// File: rtl/fpa_word_store.sv
module fpa_word_store
  import fpa_pkg::*;
#(
  parameter bit SWAP_WORDS = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobes_t       strobes,
  input  logic [SGL_W-1:0] sgWrData,
  input  logic [SGL_W-1:0] prWrFirst,
  input  logic [SGL_W-1:0] prWrSecond,
  input  logic [DBL_W-1:0] dbWrData,
  input  sIdx_t            sgRdIdx,
  input  dIdx_t            dbRdIdx,
  input  dIdx_t            prIdx,
  output logic [SGL_W-1:0] sgRdData,
  output logic [DBL_W-1:0] dbRdData,
  output logic [SGL_W-1:0] prRdFirst,
  output logic [SGL_W-1:0] prRdSecond
);
  logic [SGL_W-1:0] wordsRd [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam bit IS_ODD     = (w % 2) == 1;
    localparam bit HOLDS_HIGH = IS_ODD ^ SWAP_WORDS;
    logic [SGL_W-1:0] wordQ, nextVal, dblSlice, pairSlice;

    assign dblSlice  = HOLDS_HIGH ? dbWrData[DBL_W-1:SGL_W] : dbWrData[SGL_W-1:0];
    assign pairSlice = IS_ODD ? prWrSecond : prWrFirst;

    always_comb begin
      nextVal = wordQ;
      if (strobes.takeSgl[w])       nextVal = sgWrData;
      else if (strobes.takePair[w]) nextVal = pairSlice;
      else if (strobes.takeDbl[w])  nextVal = dblSlice;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordQ <= '0;
      else       wordQ <= nextVal;
    end

    assign wordsRd[w] = wordQ;
  end

  logic [SGL_W-1:0] dbEven, dbOdd;
  assign dbEven = wordsRd[{dbRdIdx, 1'b0}];
  assign dbOdd  = wordsRd[{dbRdIdx, 1'b1}];

  if (SWAP_WORDS) begin : g_swapped
    assign dbRdData = {dbEven, dbOdd};
  end else begin : g_natural
    assign dbRdData = {dbOdd, dbEven};
  end

  assign sgRdData   = wordsRd[sgRdIdx];
  assign prRdFirst  = wordsRd[{prIdx, 1'b0}];
  assign prRdSecond = wordsRd[{prIdx, 1'b1}];
endmodule

// File: rtl/fpa_regfile.sv
module fpa_regfile
  import fpa_pkg::*;
#(
  parameter bit SWAP_WORDS = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       sgRdField,
  input  logic             sgRdExt,
  output logic [31:0]      sgRdData,
  input  logic             sgWrEn,
  input  logic [3:0]       sgWrField,
  input  logic             sgWrExt,
  input  logic [31:0]      sgWrData,
  input  logic [3:0]       dbRdIdx,
  output logic [63:0]      dbRdData,
  input  logic             dbWrEn,
  input  logic [3:0]       dbWrIdx,
  input  logic [63:0]      dbWrData,
  input  logic [3:0]       prIdx,
  input  logic             prWrEn,
  input  logic [31:0]      prWrFirst,
  input  logic [31:0]      prWrSecond,
  output logic [31:0]      prRdFirst,
  output logic [31:0]      prRdSecond
);
  sIdx_t      sgRdIdx, sgWrIdx;
  wrStrobes_t strobes;

  assign sgRdIdx = composeSgl(sgRdField, sgRdExt);
  assign sgWrIdx = composeSgl(sgWrField, sgWrExt);

  fpa_wr_ctrl ctrl_i (
    .sgWrEn  (sgWrEn),
    .sgWrIdx (sgWrIdx),
    .prWrEn  (prWrEn),
    .prIdx   (prIdx),
    .dbWrEn  (dbWrEn),
    .dbWrIdx (dbWrIdx),
    .strobes (strobes)
  );

  fpa_word_store #(.SWAP_WORDS(SWAP_WORDS)) store_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .sgWrData   (sgWrData),
    .prWrFirst  (prWrFirst),
    .prWrSecond (prWrSecond),
    .dbWrData   (dbWrData),
    .sgRdIdx    (sgRdIdx),
    .dbRdIdx    (dbRdIdx),
    .prIdx      (prIdx),
    .sgRdData   (sgRdData),
    .dbRdData   (dbRdData),
    .prRdFirst  (prRdFirst),
    .prRdSecond (prRdSecond)
  );
endmodule

// File: rtl/fpa_regfile_chk.sv
module fpa_regfile_chk
  import fpa_pkg::*;
#(
  parameter bit SWAP_WORDS = 1'b0
) (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  sgRdField,
  input logic        sgRdExt,
  input logic [31:0] sgRdData,
  input logic        sgWrEn,
  input logic [3:0]  sgWrField,
  input logic        sgWrExt,
  input logic [31:0] sgWrData,
  input logic [3:0]  dbRdIdx,
  input logic [63:0] dbRdData,
  input logic        dbWrEn,
  input logic [3:0]  dbWrIdx,
  input logic [63:0] dbWrData,
  input logic [3:0]  prIdx,
  input logic        prWrEn,
  input logic [31:0] prWrFirst,
  input logic [31:0] prWrSecond,
  input logic [31:0] prRdFirst,
  input logic [31:0] prRdSecond
);
  sIdx_t rdIdx, wrIdx;
  assign rdIdx = composeSgl(sgRdField, sgRdExt);
  assign wrIdx = composeSgl(sgWrField, sgWrExt);

  // R1: first cycle out of reset shows cleared storage
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (sgRdData == '0 && dbRdData == '0 && prRdFirst == '0 && prRdSecond == '0));

  // R3 (and R8: single always wins)
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(sgWrEn) && rdIdx == $past(wrIdx)) |-> sgRdData == $past(sgWrData));

  // R4 / R5: double view and paired view agree on the same register
  a_r4_view_alias: assert property (@(posedge clk) disable iff (!rstN)
    (dbRdIdx == prIdx) |->
      dbRdData == (SWAP_WORDS ? {prRdFirst, prRdSecond} : {prRdSecond, prRdFirst}));

  // R6
  a_r6_pair_write: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(prWrEn) && !$past(sgWrEn) && prIdx == $past(prIdx))
      |-> (prRdFirst == $past(prWrFirst) && prRdSecond == $past(prWrSecond)));

  // R7
  a_r7_double_write: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(dbWrEn) && !$past(sgWrEn) && !$past(prWrEn) && dbRdIdx == $past(dbWrIdx))
      |-> dbRdData == $past(dbWrData));

  // R8: paired beats double on the same register
  a_r8_pair_over_double: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(prWrEn && dbWrEn && !sgWrEn && prIdx == dbWrIdx) && prIdx == $past(prIdx))
      |-> (prRdFirst == $past(prWrFirst) && prRdSecond == $past(prWrSecond)));

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(sgWrEn || prWrEn || dbWrEn) && $stable(prIdx))
      |-> ($stable(prRdFirst) && $stable(prRdSecond)));
endmodule

bind fpa_regfile fpa_regfile_chk #(.SWAP_WORDS(SWAP_WORDS)) chk_i (.*);

// File: tb/fpa_regfile_tb_top.sv
`timescale 1ns/1ps
module fpa_regfile_tb_top;
  import fpa_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  sgRdField = '0, sgWrField = '0, dbRdIdx = '0, dbWrIdx = '0, prIdx = '0;
  logic        sgRdExt = 1'b0, sgWrExt = 1'b0;
  logic        sgWrEn = 1'b0, dbWrEn = 1'b0, prWrEn = 1'b0;
  logic [31:0] sgWrData = '0, prWrFirst = '0, prWrSecond = '0;
  logic [63:0] dbWrData = '0;

  logic [31:0] sgRd [2];
  logic [63:0] dbRd [2];
  logic [31:0] prRdA [2];
  logic [31:0] prRdB [2];

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  logic [31:0] mdl [2][NUM_WORDS];

  fpa_regfile #(.SWAP_WORDS(1'b0)) dut_i (
    .clk(clk), .rstN(rstN),
    .sgRdField(sgRdField), .sgRdExt(sgRdExt), .sgRdData(sgRd[0]),
    .sgWrEn(sgWrEn), .sgWrField(sgWrField), .sgWrExt(sgWrExt), .sgWrData(sgWrData),
    .dbRdIdx(dbRdIdx), .dbRdData(dbRd[0]),
    .dbWrEn(dbWrEn), .dbWrIdx(dbWrIdx), .dbWrData(dbWrData),
    .prIdx(prIdx), .prWrEn(prWrEn), .prWrFirst(prWrFirst), .prWrSecond(prWrSecond),
    .prRdFirst(prRdA[0]), .prRdSecond(prRdB[0]));

  fpa_regfile #(.SWAP_WORDS(1'b1)) dutSw_i (
    .clk(clk), .rstN(rstN),
    .sgRdField(sgRdField), .sgRdExt(sgRdExt), .sgRdData(sgRd[1]),
    .sgWrEn(sgWrEn), .sgWrField(sgWrField), .sgWrExt(sgWrExt), .sgWrData(sgWrData),
    .dbRdIdx(dbRdIdx), .dbRdData(dbRd[1]),
    .dbWrEn(dbWrEn), .dbWrIdx(dbWrIdx), .dbWrData(dbWrData),
    .prIdx(prIdx), .prWrEn(prWrEn), .prWrFirst(prWrFirst), .prWrSecond(prWrSecond),
    .prRdFirst(prRdA[1]), .prRdSecond(prRdB[1]));

  function automatic logic [63:0] expDbl(int s, int n);
    return (s != 0) ? {mdl[s][2*n], mdl[s][2*n+1]} : {mdl[s][2*n+1], mdl[s][2*n]};
  endfunction

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    int si;
    si = {sgRdField, sgRdExt};
    for (int s = 0; s < 2; s++) begin
      cmp(tag, "single", 64'(sgRd[s]), 64'(mdl[s][si]));
      cmp(tag, "double", dbRd[s], expDbl(s, int'(dbRdIdx)));
      cmp(tag, "pairFirst", 64'(prRdA[s]), 64'(mdl[s][2*int'(prIdx)]));
      cmp(tag, "pairSecond", 64'(prRdB[s]), 64'(mdl[s][2*int'(prIdx)+1]));
    end
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < NUM_WORDS; i++) begin
      sgRdField = 4'(i >> 1);
      sgRdExt   = i[0];
      dbRdIdx   = 4'(i >> 1);
      prIdx     = 4'(i >> 1);
      #1;
      checkAll(tag);
    end
  endtask

  // reference update: double, then pair, then single (later overwrites earlier)
  task automatic updModels();
    for (int s = 0; s < 2; s++) begin
      if (dbWrEn) begin
        if (s == 0) begin
          mdl[s][2*dbWrIdx]   = dbWrData[31:0];
          mdl[s][2*dbWrIdx+1] = dbWrData[63:32];
        end else begin
          mdl[s][2*dbWrIdx]   = dbWrData[63:32];
          mdl[s][2*dbWrIdx+1] = dbWrData[31:0];
        end
      end
      if (prWrEn) begin
        mdl[s][2*prIdx]   = prWrFirst;
        mdl[s][2*prIdx+1] = prWrSecond;
      end
      if (sgWrEn) mdl[s][{sgWrField, sgWrExt}] = sgWrData;
    end
  endtask

  task automatic cycle();
    updModels();
    @(posedge clk);
    @(negedge clk);
    sgWrEn = 1'b0; dbWrEn = 1'b0; prWrEn = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < NUM_WORDS; w++) mdl[s][w] = '0;

    repeat (3) @(negedge clk);
    sweep("R1");
    rstN = 1'b1;
    @(negedge clk);
    sweep("R1");

    // R2: field 5, ext 1 -> word 11 = upper half of double 5 (natural order)
    sgWrEn = 1'b1; sgWrField = 4'd5; sgWrExt = 1'b1; sgWrData = 32'hA5A5_0001;
    cycle();
    dbRdIdx = 4'd5; sgRdField = 4'd5; sgRdExt = 1'b1; #1;
    cmp("R2", "upper half natural", 64'(dbRd[0][63:32]), 64'h0000_0000_A5A5_0001);
    cmp("R2", "lower half swapped", 64'(dbRd[1][31:0]), 64'h0000_0000_A5A5_0001);
    checkAll("R2");

    // R3: negative integer bits preserved
    sgWrEn = 1'b1; sgWrField = 4'd0; sgWrExt = 1'b0; sgWrData = 32'(-7);
    cycle();
    sgRdField = 4'd0; sgRdExt = 1'b0; #1;
    cmp("R3", "neg int", 64'(sgRd[0]), 64'h0000_0000_FFFF_FFF9);
    checkAll("R3");

    // R4 / R5 / R7: double write, view through paired port
    dbWrEn = 1'b1; dbWrIdx = 4'd3; dbWrData = 64'h1122_3344_5566_7788;
    cycle();
    prIdx = 4'd3; dbRdIdx = 4'd3; #1;
    cmp("R4", "even word natural", 64'(prRdA[0]), 64'h0000_0000_5566_7788);
    cmp("R4", "odd word natural", 64'(prRdB[0]), 64'h0000_0000_1122_3344);
    cmp("R5", "even word swapped", 64'(prRdA[1]), 64'h0000_0000_1122_3344);
    cmp("R7", "double natural", dbRd[0], 64'h1122_3344_5566_7788);
    cmp("R7", "double swapped", dbRd[1], 64'h1122_3344_5566_7788);

    // R6: paired write independent of order parameter
    prWrEn = 1'b1; prIdx = 4'd7; prWrFirst = 32'hCAFE_0001; prWrSecond = 32'hBEEF_0002;
    cycle();
    sgRdField = 4'd7; sgRdExt = 1'b0; #1;
    cmp("R6", "word14 natural", 64'(sgRd[0]), 64'h0000_0000_CAFE_0001);
    cmp("R6", "word14 swapped", 64'(sgRd[1]), 64'h0000_0000_CAFE_0001);
    sgRdExt = 1'b1; dbRdIdx = 4'd7; #1;
    cmp("R6", "word15 natural", 64'(sgRd[0]), 64'h0000_0000_BEEF_0002);
    cmp("R6", "double of pair", dbRd[0], 64'hBEEF_0002_CAFE_0001);
    checkAll("R6");

    // R8: all three writers on register 9, single on word 19
    dbWrEn = 1'b1; dbWrIdx = 4'd9; dbWrData = 64'hD1D1_D1D1_D0D0_D0D0;
    prWrEn = 1'b1; prIdx = 4'd9; prWrFirst = 32'h0000_AAAA; prWrSecond = 32'h0000_BBBB;
    sgWrEn = 1'b1; sgWrField = 4'd9; sgWrExt = 1'b1; sgWrData = 32'h5151_5151;
    cycle();
    #1;
    cmp("R8", "even from pair", 64'(prRdA[0]), 64'h0000_0000_0000_AAAA);
    cmp("R8", "odd from single", 64'(prRdB[1]), 64'h0000_0000_5151_5151);
    checkAll("R8");
    // double + single on register 11, single takes word 22
    dbWrEn = 1'b1; dbWrIdx = 4'd11; dbWrData = 64'hEEEE_0001_FFFF_0002;
    sgWrEn = 1'b1; sgWrField = 4'd11; sgWrExt = 1'b0; sgWrData = 32'h7777_7777;
    cycle();
    prIdx = 4'd11; #1;
    cmp("R8", "odd natural from double", 64'(prRdB[0]), 64'h0000_0000_EEEE_0001);
    cmp("R8", "odd swapped from double", 64'(prRdB[1]), 64'h0000_0000_FFFF_0002);
    cmp("R8", "even from single", 64'(prRdA[1]), 64'h0000_0000_7777_7777);
    // double + pair on register 12
    dbWrEn = 1'b1; dbWrIdx = 4'd12; dbWrData = 64'h1234_5678_9ABC_DEF0;
    prWrEn = 1'b1; prIdx = 4'd12; prWrFirst = 32'h0101_0101; prWrSecond = 32'h0202_0202;
    cycle();
    dbRdIdx = 4'd12; #1;
    cmp("R8", "pair beats double", dbRd[0], 64'h0202_0202_0101_0101);
    checkAll("R8");

    // R10: change read indices with no clock edge
    sgRdField = 4'd3; sgRdExt = 1'b1; dbRdIdx = 4'd7; prIdx = 4'd5; #1;
    checkAll("R10");
    sgRdField = 4'd12; sgRdExt = 1'b0; dbRdIdx = 4'd9; prIdx = 4'd3; #1;
    checkAll("R10");

    // R9: data toggles, enables low
    sgWrData = $urandom; dbWrData = {$urandom, $urandom};
    prWrFirst = $urandom; prWrSecond = $urandom;
    sgWrField = 4'd2; dbWrIdx = 4'd2; prIdx = 4'd2;
    cycle();
    sweep("R9");

    // random mix, conflicts provoked often
    for (int k = 0; k < 500; k++) begin
      sgWrEn = $urandom_range(0, 1) == 1;
      dbWrEn = $urandom_range(0, 1) == 1;
      prWrEn = $urandom_range(0, 1) == 1;
      sgWrField = 4'($urandom); sgWrExt = 1'($urandom);
      dbWrIdx = 4'($urandom); prIdx = 4'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        dbWrIdx = sgWrField; prIdx = sgWrField;
      end
      sgWrData = $urandom; dbWrData = {$urandom, $urandom};
      prWrFirst = $urandom; prWrSecond = $urandom;
      cycle();
      sgRdField = 4'($urandom); sgRdExt = 1'($urandom);
      dbRdIdx = 4'($urandom); prIdx = 4'($urandom);
      #1;
      checkAll("R8");
    end
    sweep("R7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule